// File: doc/BRIEF.md
# Page-Table Walk Engine for TLB Misses

This block resolves a translation miss in hardware. When the translation buffer cannot find a virtual page number, it hands the walker that page number together with the kind of access that was attempted. The walker forms the address of the matching entry in a flat, single-level table that starts at a base register. It fetches that 32-bit entry over a request/response memory port, then judges it.

A usable entry is written into the translation buffer, tagged with the address-space identifier of the process that missed, and the pipeline is told to replay the instruction. An entry that is not present, or one whose permissions do not cover the access, produces a fault with a cause code instead. In that case nothing is written into the buffer.

The walker handles one miss at a time. It reports busy from the moment it accepts a miss until it has finished with it.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and in the first idle cycle after it, busy, mem_req_valid, ins_valid, retry and fault are all low.
- R2: A miss accepted in idle produces exactly one read request, whose address is ptbr + vpn*4 modulo 2^ADDR_W. The request is driven in the cycle after acceptance.
- R3: Until mem_req_ready is seen high, mem_req_valid stays high and mem_req_addr does not change.
- R4: The walker waits for the response for any number of cycles. While it waits it makes no insert, retry or fault.
- R5: If bit 0 (present) of the fetched entry is 0, fault pulses with fault_cause = 1 and no insert happens. This check takes precedence over the permission check.
- R6: Entry bits 3:1 grant read, write and execute, one bit each, with read in bit 1. The access code miss_acc uses bit 0 for read, bit 1 for write and bit 2 for execute. If a present entry lacks any requested right, fault pulses with fault_cause = 2 and no insert happens.
- R7: Otherwise ins_valid pulses for one cycle, two cycles after the response is taken. The insert carries the missing vpn, the frame number from entry bits 31:12, the entry's three permission bits and the latched ASID. Entry bits 11:4 have no effect.
- R8: retry pulses for one cycle, in the cycle after the insert. retry and fault each last one cycle and never assert together.
- R9: busy is high in every cycle from the one after acceptance until the walk ends. A miss presented while busy is ignored.
- R10: ASID and table base are captured when the miss is accepted. Later changes on asid_cur or ptbr do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Translation miss presented |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_acc | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| asid_cur | input | ASID_W | Address-space identifier of the running process |
| ptbr | input | ADDR_W | Byte address of the page table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Fetched page-table entry |
| ins_valid | output | 1 | Write translation into the TLB |
| ins_vpn | output | VPN_W | Page number for the insert |
| ins_pfn | output | 20 | Frame number for the insert |
| ins_prot | output | 3 | Permissions for the insert (read in bit 0) |
| ins_asid | output | ASID_W | Address-space tag for the insert |
| retry | output | 1 | Replay the missing instruction |
| fault | output | 1 | Walk ended in a segmentation fault |
| fault_cause | output | 2 | 1 = entry not present, 2 = permission denied |

## Verification
The hardest case to reach is a walk that stays open across changes at its own inputs. That means a second miss arriving while the request is stalled, the base and ASID changing after acceptance, and a response that only comes several cycles later. The bench sweeps every combination of present bit, permission bits and requested access. For each walk it varies the request stall and the response delay arithmetically. On odd access codes it also presents an extra miss during the stall. After every acceptance it scrambles asid_cur and ptbr, so any reliance on live inputs shows up in the address or in the insert fields.

// File: rtl/pgwalk_pkg.sv
// Package: shared encodings for the page-table walker.
// Assumes a 32-bit single-level page-table entry laid out as
// present(0), read(1), write(2), execute(3), frame number(31:12).
package pgwalk_pkg;

    localparam int PTE_W       = 32;
    localparam int PTE_BYTES   = PTE_W / 8;
    localparam int PRESENT_BIT = 0;
    localparam int PERM_LSB    = 1;
    localparam int PERM_W      = 3;
    localparam int PFN_LSB     = 12;
    localparam int PFN_W       = PTE_W - PFN_LSB;

    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_REQ    = 3'd1,
        WS_WAIT   = 3'd2,
        WS_CHECK  = 3'd3,
        WS_INSERT = 3'd4,
        WS_DONE   = 3'd5,
        WS_FAULT  = 3'd6
    } walk_state_t;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_ABSENT  = 2'd1,
        FC_DENIED  = 2'd2
    } fault_cause_t;

endpackage

// File: rtl/pgwalk_addr.sv
// Module: entry address generator.
// Forms base + page_number * entry size for a flat table.
// Assumes ADDR_W >= VPN_W + log2(entry size). The sum wraps modulo 2^ADDR_W.
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] addr
);
    localparam int SCALE_SHIFT = $clog2(PTE_BYTES);

    logic [ADDR_W-1:0] offset;

    // Scale the page number to a byte offset and add the table base.
    always_comb begin
        offset = ADDR_W'(vpn) << SCALE_SHIFT;
        addr   = base + offset;
    end
endmodule

// File: rtl/pgwalk_check.sv
// Module: entry judge.
// Decodes a fetched entry and decides between insert, absent-fault and
// permission-fault. Presence is tested before permissions.
// Assumes the access code and the permission field share bit order (r,w,x).
module pgwalk_check
    import pgwalk_pkg::*;
(
    input  logic               present,
    input  logic [PERM_W-1:0]  perm,
    input  logic [PERM_W-1:0]  acc,
    output fault_cause_t       cause
);
    logic denied;

    // A right that is requested but not granted makes the access illegal.
    always_comb begin
        denied = |(acc & ~perm);
        if (!present)
            cause = FC_ABSENT;
        else if (denied)
            cause = FC_DENIED;
        else
            cause = FC_NONE;
    end
endmodule

// File: rtl/pgwalk_fsm.sv
// Module: walk sequencer.
// Steps idle -> request -> wait -> check -> insert/fault -> (retry) -> idle.
// Accepts a miss only in idle. Assumes the request handshake completes
// when valid and ready are both high at a clock edge.
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         miss_valid,
    input  logic         req_ready,
    input  logic         rsp_valid,
    input  fault_cause_t check_cause,
    output walk_state_t  state,
    output logic         accept_miss,
    output logic         take_rsp
);
    walk_state_t state_nx;

    // Choose the next step of the walk.
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:   if (miss_valid) state_nx = WS_REQ;
            WS_REQ:    if (req_ready)  state_nx = WS_WAIT;
            WS_WAIT:   if (rsp_valid)  state_nx = WS_CHECK;
            WS_CHECK:  state_nx = (check_cause == FC_NONE) ? WS_INSERT : WS_FAULT;
            WS_INSERT: state_nx = WS_DONE;
            WS_DONE:   state_nx = WS_IDLE;
            WS_FAULT:  state_nx = WS_IDLE;
            default:   state_nx = WS_IDLE;
        endcase
    end

    // Hold the current step; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WS_IDLE;
        else
            state <= state_nx;
    end

    // Capture strobes for the datapath registers.
    always_comb begin
        accept_miss = (state == WS_IDLE) && miss_valid;
        take_rsp    = (state == WS_WAIT) && rsp_valid;
    end
endmodule

// File: rtl/pgwalk_top.sv
// Module: hardware page-table walker top.
// On a translation miss, reads one entry of a flat table, then either
// inserts the translation tagged with the captured ASID and requests a
// replay, or reports a fault with a cause code. One walk at a time.
// Assumes the memory returns exactly one response per accepted request.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [2:0]        miss_acc,
    input  logic [ASID_W-1:0] asid_cur,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              ins_valid,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [19:0]       ins_pfn,
    output logic [2:0]        ins_prot,
    output logic [ASID_W-1:0] ins_asid,
    output logic              retry,
    output logic              fault,
    output logic [1:0]        fault_cause
);
    walk_state_t       state;
    logic              accept_miss;
    logic              take_rsp;
    fault_cause_t      chk_cause;

    logic [VPN_W-1:0]  vpn_q;
    logic [PERM_W-1:0] acc_q;
    logic [ASID_W-1:0] asid_q;
    logic [ADDR_W-1:0] base_q;
    logic              present_q;
    logic [PERM_W-1:0] perm_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              rsvd_unused;

    // Reserved entry bits carry no meaning for the walk.
    assign rsvd_unused = ^mem_rsp_data[PFN_LSB-1:PERM_LSB+PERM_W];

    // Capture the miss context at acceptance so live inputs may change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            acc_q  <= '0;
            asid_q <= '0;
            base_q <= '0;
        end else if (accept_miss) begin
            vpn_q  <= miss_vpn;
            acc_q  <= miss_acc;
            asid_q <= asid_cur;
            base_q <= ptbr;
        end
    end

    // Capture the fields of the fetched entry when the response arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0;
            perm_q    <= '0;
            pfn_q     <= '0;
        end else if (take_rsp) begin
            present_q <= mem_rsp_data[PRESENT_BIT];
            perm_q    <= mem_rsp_data[PERM_LSB +: PERM_W];
            pfn_q     <= mem_rsp_data[PFN_LSB +: PFN_W];
        end
    end

    pgwalk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .check_cause (chk_cause),
        .state       (state),
        .accept_miss (accept_miss),
        .take_rsp    (take_rsp)
    );

    pgwalk_addr #(
        .VPN_W  (VPN_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base (base_q),
        .vpn  (vpn_q),
        .addr (mem_req_addr)
    );

    pgwalk_check u_check (
        .present (present_q),
        .perm    (perm_q),
        .acc     (acc_q),
        .cause   (chk_cause)
    );

    // Decode handshake and pulse outputs from the registered step.
    always_comb begin
        busy          = (state != WS_IDLE);
        mem_req_valid = (state == WS_REQ);
        ins_valid     = (state == WS_INSERT);
        retry         = (state == WS_DONE);
        fault         = (state == WS_FAULT);
        fault_cause   = (state == WS_FAULT) ? chk_cause : FC_NONE;
        ins_vpn       = vpn_q;
        ins_pfn       = pfn_q;
        ins_prot      = perm_q;
        ins_asid      = asid_q;
    end
endmodule

// File: rtl/pgwalk_sva.sv
// Module: protocol checker for pgwalk_top, attached by bind.
// Observes ports only.
module pgwalk_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              ins_valid,
    input logic              retry,
    input logic              fault,
    input logic [1:0]        fault_cause
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry && fault));

    a_r8_retry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !retry);

    a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    a_r7_retry_follows_insert: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> retry);

    a_r5_fault_no_insert: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !ins_valid && fault_cause != 2'd0);

    a_r9_busy_covers_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || ins_valid) |-> busy);
endmodule

bind pgwalk_top pgwalk_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .ins_valid     (ins_valid),
    .retry         (retry),
    .fault         (fault),
    .fault_cause   (fault_cause)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [19:0] miss_vpn;
    logic [2:0]  miss_acc;
    logic [7:0]  asid_cur;
    logic [31:0] ptbr;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        ins_valid;
    logic [19:0] ins_vpn;
    logic [19:0] ins_pfn;
    logic [2:0]  ins_prot;
    logic [7:0]  ins_asid;
    logic        retry;
    logic        fault;
    logic [1:0]  fault_cause;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .miss_acc(miss_acc), .asid_cur(asid_cur), .ptbr(ptbr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
        .ins_pfn(ins_pfn), .ins_prot(ins_prot), .ins_asid(ins_asid),
        .retry(retry), .fault(fault), .fault_cause(fault_cause)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [19:0] vpn, input logic [2:0] acc,
                        input logic [7:0] asid, input logic [31:0] base,
                        input logic [31:0] pte, input int rdly, input int pdly,
                        input bit poke);
        logic [31:0] exp_addr;
        logic [1:0]  exp_cause;
        exp_addr = base + {10'b0, vpn, 2'b00};
        if (!pte[0])                  exp_cause = 2'd1;
        else if ((acc & ~pte[3:1]) != 0) exp_cause = 2'd2;
        else                          exp_cause = 2'd0;

        miss_valid = 1'b1; miss_vpn = vpn; miss_acc = acc;
        asid_cur = asid; ptbr = base;
        @(negedge clk);
        miss_valid = 1'b0;
        asid_cur = ~asid; ptbr = base ^ 32'h5A5A_0F00;   // R10 scramble
        miss_vpn = ~vpn;
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        check(mem_req_valid == 1'b1, "R2 request issued", mem_req_valid, 1);
        check(mem_req_addr == exp_addr, "R2 R10 entry address", mem_req_addr, exp_addr);
        for (int i = 0; i < rdly; i++) begin
            if (poke) begin miss_valid = 1'b1; miss_acc = ~acc; end
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr, "R3 request held",
                  mem_req_addr, exp_addr);
        end
        miss_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R2 single request", mem_req_valid, 0);
        for (int i = 0; i < pdly; i++) begin
            @(negedge clk);
            check(busy && !ins_valid && !fault && !retry && !mem_req_valid,
                  "R4 wait quiet", {ins_valid, fault, retry}, 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~pte;
        check(!ins_valid && !fault && !retry, "R4 check step quiet",
              {ins_valid, fault, retry}, 0);
        @(negedge clk);
        if (exp_cause == 2'd0) begin
            check(ins_valid && !fault && !retry, "R7 insert pulse",
                  {ins_valid, fault, retry}, 3'b100);
            check(ins_vpn == vpn, "R7 insert vpn", ins_vpn, vpn);
            check(ins_pfn == pte[31:12], "R7 insert pfn", ins_pfn, pte[31:12]);
            check(ins_prot == pte[3:1], "R7 insert prot", ins_prot, pte[3:1]);
            check(ins_asid == asid, "R10 insert asid", ins_asid, asid);
            @(negedge clk);
            check(retry && !ins_valid && !fault, "R8 retry after insert",
                  {ins_valid, fault, retry}, 3'b001);
            @(negedge clk);
            check(!retry && !busy, "R8 retry one cycle", {retry, busy}, 0);
        end else begin
            check(fault && !ins_valid && !retry,
                  exp_cause == 2'd1 ? "R5 absent fault" : "R6 denied fault",
                  {ins_valid, fault, retry}, 3'b010);
            check(fault_cause == exp_cause,
                  exp_cause == 2'd1 ? "R5 cause" : "R6 cause", fault_cause, exp_cause);
            @(negedge clk);
            check(!fault && !busy && !ins_valid && !retry, "R8 fault one cycle",
                  {fault, busy, ins_valid, retry}, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; miss_valid = 1'b0; miss_vpn = '0; miss_acc = '0;
        asid_cur = '0; ptbr = '0; mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req_valid && !ins_valid && !retry && !fault,
              "R1 reset quiet", {busy, mem_req_valid, ins_valid, retry, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req_valid && !ins_valid && !retry && !fault,
              "R1 idle after reset", {busy, mem_req_valid, ins_valid, retry, fault}, 0);

        for (int p = 0; p < 16; p++) begin
            for (int a = 0; a < 8; a++) begin
                logic [19:0] vpn;
                logic [31:0] pte;
                vpn = 20'((p * 37 + a * 1013 + 5) * 97);
                pte = {20'((p + 1) * 4099 + a * 17), 8'hA5 ^ 8'(p * a), 4'(p)};
                walk(vpn, 3'(a), 8'(p * 16 + a), 32'h8000_0000 + 32'(p * 4096),
                     pte, (p + a) % 3, (p * a) % 4, a[0]);
            end
        end
        // Address wrap with the largest page number and a high base.
        walk(20'hFFFFF, 3'b001, 8'h3C, 32'hFFFF_F000, 32'h1234_5003, 2, 5, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule